// File: doc/BRIEF.md
# Selectable-Order Burst Address Counter

This block produces the address sequence for a four-beat burst. A start strobe loads a full starting address. After that, each advance request moves the two lowest address bits to the next beat of the burst. The bits above them stay the same for the whole burst.

A static order input picks one of two orders:
- **Linear:** the low two bits count up and wrap modulo four.
- **Interleaved:** the low two bits of the starting address are XOR-ed with a beat count.

The counter wraps after four beats. It never carries into the upper address bits.

A memory controller uses it to step through a cache line without issuing new addresses. A start that arrives during a burst throws away the burst in progress and begins a new one.

Top module: `burst_addr_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, `addr_o` becomes 0 and the beat count clears. This is visible after that edge.
- R2: When `start_i` is high at a rising edge, `addr_o` equals `start_addr_i` after that edge, and the beat count returns to 0.
- R3: `start_i` takes priority over `adv_n_i`. A start while a burst is in progress, even with `adv_n_i` low, replaces the burst and begins again at beat 0.
- R4: When `start_i` is low and `adv_n_i` is high (advance is active low) at an edge, `addr_o` keeps its value.
- R5: When `order_sel_i` = 0 (linear), after k advances the low two bits equal (start_low + k) mod 4. For example, a start offset of 2 gives 2, 3, 0, 1.
- R6: When `order_sel_i` = 1 (interleaved), after k advances the low two bits equal start_low XOR (k mod 4). For example, a start offset of 1 gives 1, 0, 3, 2.
- R7: Bits above bit 1 of `addr_o` change only on a start. After four advances `addr_o` is back at the starting address.
- R8: `order_sel_i` is a static strap. It may change only while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load a new starting address and begin a burst |
| start_addr_i | input | ADDR_W | Starting address of the burst |
| adv_n_i | input | 1 | Advance to the next beat, active low |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst address |

## Verification
Every result is due one edge after its stimulus: a load, an advance, a hold or a reset is visible just after the rising edge that samples it.

The bench drives inputs on the falling edge. It checks `addr_o` one time unit after the next rising edge, using a beat count and start offset that it keeps for itself.

For each order, the bench sweeps all four start offsets with stalls mixed in. It also sweeps a reload in the middle of a burst. No result is ever expected two edges late.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic  load;
        logic  step;
    } burst_ctl_t;

    function automatic beat_t map_low(input burst_order_e ord,
                                      input beat_t base,
                                      input beat_t beat);
        beat_t r;
        case (ord)
            ORD_LINEAR:     r = base + beat;
            ORD_INTERLEAVE: r = base ^ beat;
            default:        r = base;
        endcase
        return r;
    endfunction

    function automatic burst_ctl_t decode_ctl(input logic start,
                                              input logic adv_n);
        burst_ctl_t c;
        c.load = start;
        c.step = !start && !adv_n;
        return c;
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  step,
    output beat_t beat_o
);
    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst || clear) beat_q <= '0;
        else if (step)    beat_q <= beat_q + beat_t'(1);
    end

    assign beat_o = beat_q;

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clear && step) |=> (beat_o == beat_t'($past(beat_o) + beat_t'(1)))); // R5
    AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> (beat_o == '0)); // R3

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [ADDR_W-1:BEAT_W]   upper_o,
    output beat_t                    low_o
);
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst)       base_q <= '0;
        else if (load) base_q <= addr_i;
    end

    assign upper_o = base_q[ADDR_W-1:BEAT_W];
    assign low_o   = base_q[BEAT_W-1:0];

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(upper_o)); // R7

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              adv_n_i,
    input  logic              order_sel_i,
    output logic [ADDR_W-1:0] addr_o
);
    burst_ctl_t                ctl;
    beat_t                     beat;
    beat_t                     base_low;
    logic [ADDR_W-1:BEAT_W]    base_up;
    burst_order_e              order;

    assign ctl   = decode_ctl(start_i, adv_n_i);
    assign order = burst_order_e'(order_sel_i);

    burst_beat_ctr u_beat (
        .clk    (clk),
        .rst    (rst),
        .clear  (ctl.load),
        .step   (ctl.step),
        .beat_o (beat)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.load),
        .addr_i  (start_addr_i),
        .upper_o (base_up),
        .low_o   (base_low)
    );

    always_comb addr_o = {base_up, map_low(order, base_low, beat)};

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (addr_o == $past(start_addr_i))); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start_i && adv_n_i) |=> $stable(addr_o)); // R4
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !adv_n_i && !order_sel_i)
        |=> (addr_o[BEAT_W-1:0] == beat_t'($past(addr_o[BEAT_W-1:0]) + beat_t'(1)))); // R5
    AST_ORDER_STATIC: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(order_sel_i)); // R8

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic [AW-1:0] start_addr_i;
    logic          adv_n_i;
    logic          order_sel_i;
    logic [AW-1:0] addr_o;

    int n_vec  = 0;
    int n_fail = 0;

    logic [AW-1:2] m_up;
    logic [1:0]    m_base;
    int            m_k;
    logic          m_ord;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .adv_n_i      (adv_n_i),
        .order_sel_i  (order_sel_i),
        .addr_o       (addr_o)
    );

    function automatic logic [AW-1:0] expected();
        logic [1:0] k2;
        logic [1:0] lo;
        k2 = 2'(m_k % 4);
        lo = m_ord ? (m_base ^ k2) : 2'((m_base + k2) % 4);
        return {m_up, lo};
    endfunction

    task automatic check(input logic [AW-1:0] exp, input string req);
        n_vec++;
        if (addr_o !== exp) begin
            n_fail++;
            $display("FAIL %s: addr_o=%h expected %h", req, addr_o, exp);
        end
    endtask

    task automatic do_reset(input logic ord);
        @(negedge clk);
        rst = 1'b1; start_i = 1'b0; adv_n_i = 1'b1; order_sel_i = ord;
        start_addr_i = '0;
        @(posedge clk); #1;
        m_up = '0; m_base = '0; m_k = 0; m_ord = ord;
        check('0, "R1");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cycle(input logic st, input logic [AW-1:0] a,
                         input logic advn, input string req);
        @(negedge clk);
        start_i = st; start_addr_i = a; adv_n_i = advn;
        @(posedge clk); #1;
        if (st) begin
            m_up = a[AW-1:2]; m_base = a[1:0]; m_k = 0;
        end else if (!advn) begin
            m_k++;
        end
        check(expected(), req);
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; adv_n_i = 1'b1;
        order_sel_i = 1'b0; start_addr_i = '0;
        for (int ord = 0; ord < 2; ord++) begin
            do_reset(1'(ord));
            for (int off = 0; off < 4; off++) begin
                logic [AW-1:0] sa;
                sa = {18'(20'h3A5C7 + off * 1111), 2'(off)};
                cycle(1'b1, sa, 1'b1, "R2");
                for (int b = 0; b < 6; b++) begin
                    cycle(1'b0, '0, 1'b0, ord ? "R6" : "R5");
                    if (b == 1) cycle(1'b0, '0, 1'b1, "R4");
                end
                // after 6 advances two more complete the wrap
                cycle(1'b0, '0, 1'b0, "R7");
                cycle(1'b0, '0, 1'b0, "R7");
                if (addr_o !== sa) begin
                    n_fail++;
                    $display("FAIL R7: addr_o=%h expected %h", addr_o, sa);
                end
                n_vec++;
                // reload mid-burst with advance also asserted
                cycle(1'b0, '0, 1'b0, "R8");
                cycle(1'b1, sa ^ 20'hF0F03, 1'b0, "R3");
                cycle(1'b0, '0, 1'b0, "R3");
                cycle(1'b0, '0, 1'b1, "R4");
            end
        end
        do_reset(1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule